// File: doc/BRIEF.md
# Row-Bypassing Unsigned Array Multiplier

This block multiplies two unsigned N-bit operands with no clock, giving a 2N-bit product. It is a carry-save array. A seed row forms the first partial product. Each later row adds one shifted partial product into a redundant pair of sum and carry vectors. A ripple-carry adder then merges that pair into the product.

Every carry-save row is controlled by the multiplier bit that selects its partial product. When that bit is zero, the row's adder inputs are forced to zero so they do not toggle. Its output multiplexers pass the incoming sum and carry vectors on unchanged, so a zero multiplier bit costs no adder activity in its row. A flag vector shows which rows are computing.

Top module: `rbm_mult`

## Requirements
- R1: For every pair of operands, `p_o` equals the unsigned product `a_i * b_i`, including the product 1011 × 1010 = 110, which is formed with the row for bit 2 of `b_i` bypassed.
- R2: `row_active_o[j-1]` is 1 exactly when `b_i[j]` is 1, for j = 1 .. N-1. Bit 0 of the flag vector belongs to the row of multiplier bit 1. A 0 flag means that row passes its incoming sum and carry through unchanged.
- R3: When `b_i` is zero, `p_o` is zero and every row flag is 0.
- R4: When `a_i` is zero, `p_o` is zero, whatever the row flags are.
- R5: When `b_i` is 1, `p_o` equals `a_i` zero-extended, with every row bypassed.
- R6: When `b_i` is 2^k, `p_o` equals `a_i` shifted left by k, with at most one row active.
- R7: The largest product (all-ones times all-ones) is exact. No carry leaves the top bit of any carry-save row or of the final adder.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | N | Unsigned multiplicand |
| b_i | input | N | Unsigned multiplier; bit j steers carry-save row j |
| p_o | output | 2N | Unsigned product |
| row_active_o | output | N-1 | Per-row compute flag for multiplier bits N-1..1 |

## Verification
The bench sweeps all 256 operand pairs of the 4-bit configuration. For every pair it compares the product with an arithmetic reference and compares the flags with the multiplier bits. A row whose bypass multiplexer picked the wrong source, or whose carry was not shifted, would break any pair that uses that row. Directed cases cover a zero multiplier, a zero multiplicand, a unit multiplier, single-bit multipliers and the all-ones product. These expose a seed row that ignores bit 0, a flag vector off by one row, and a carry lost from the top column. The 1011 × 1010 case makes the bypassed row sit between two active rows. A design whose bypass dropped the carry vector would get this product wrong.

// File: rtl/rbm_pkg.sv
package rbm_pkg;
  function automatic logic fa_sum(input logic x, input logic y, input logic z);
    return x ^ y ^ z;
  endfunction

  function automatic logic fa_maj(input logic x, input logic y, input logic z);
    return (x & y) | (x & z) | (y & z);
  endfunction
endpackage

// File: rtl/rbm_add_cell.sv
module rbm_add_cell
  import rbm_pkg::*;
(
  input  logic en_i,
  input  logic pp_i,
  input  logic sum_i,
  input  logic carry_i,
  input  logic cgen_lo_i,
  output logic sum_o,
  output logic carry_o,
  output logic cgen_o
);
  logic x_g, y_g, z_g;

  // operand gating: adder inputs held at zero while bypassed
  assign x_g = pp_i & en_i;
  assign y_g = sum_i & en_i;
  assign z_g = carry_i & en_i;

  assign cgen_o  = fa_maj(x_g, y_g, z_g);
  assign sum_o   = en_i ? fa_sum(x_g, y_g, z_g) : sum_i;
  assign carry_o = en_i ? cgen_lo_i : carry_i;
endmodule

// File: rtl/rbm_csa_row.sv
module rbm_csa_row #(
  parameter int W = 8
) (
  input  logic         en_i,
  input  logic [W-1:0] pp_i,
  input  logic [W-1:0] sum_i,
  input  logic [W-1:0] carry_i,
  output logic [W-1:0] sum_o,
  output logic [W-1:0] carry_o
);
  logic [W:0] gen;

  assign gen[0] = 1'b0;

  for (genvar i = 0; i < W; i++) begin : g_cell
    rbm_add_cell u_cell (
      .en_i     (en_i),
      .pp_i     (pp_i[i]),
      .sum_i    (sum_i[i]),
      .carry_i  (carry_i[i]),
      .cgen_lo_i(gen[i]),
      .sum_o    (sum_o[i]),
      .carry_o  (carry_o[i]),
      .cgen_o   (gen[i+1])
    );
  end

  always_comb begin
    if (!en_i) begin
      assert_bypass_pass_R2: assert (sum_o == sum_i && carry_o == carry_i)
        else $error("bypassed row altered its vectors");
    end
    // partial sums never reach 2^W, so the top carry is always zero
    assert_no_overflow_R7: assert (gen[W] == 1'b0)
      else $error("carry left top of carry-save row");
  end
endmodule

// File: rtl/rbm_ripple.sv
module rbm_ripple
  import rbm_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  output logic [W-1:0] sum_o
);
  logic [W:0] c;

  assign c[0] = 1'b0;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign sum_o[i] = fa_sum(x_i[i], y_i[i], c[i]);
    assign c[i+1]   = fa_maj(x_i[i], y_i[i], c[i]);
  end

  always_comb begin
    assert_final_carry_R7: assert (c[W] == 1'b0)
      else $error("carry left top of final adder");
  end
endmodule

// File: rtl/rbm_mult.sv
module rbm_mult #(
  parameter int N = 4
) (
  input  logic [N-1:0]   a_i,
  input  logic [N-1:0]   b_i,
  output logic [2*N-1:0] p_o,
  output logic [N-2:0]   row_active_o
);
  localparam int W = 2 * N;

  logic [W-1:0] s_stage [N];
  logic [W-1:0] c_stage [N];
  logic [W-1:0] a_ext;

  assign a_ext      = W'(a_i);
  assign s_stage[0] = a_ext & {W{b_i[0]}};
  assign c_stage[0] = '0;

  for (genvar j = 1; j < N; j++) begin : g_row
    rbm_csa_row #(.W(W)) u_row (
      .en_i   (b_i[j]),
      .pp_i   (a_ext << j),
      .sum_i  (s_stage[j-1]),
      .carry_i(c_stage[j-1]),
      .sum_o  (s_stage[j]),
      .carry_o(c_stage[j])
    );
    assign row_active_o[j-1] = b_i[j];
  end

  rbm_ripple #(.W(W)) u_final (
    .x_i  (s_stage[N-1]),
    .y_i  (c_stage[N-1]),
    .sum_o(p_o)
  );

  always_comb begin
    assert_exact_R1: assert (p_o == a_ext * W'(b_i))
      else $error("product mismatch");
    if (b_i == '0) begin
      assert_zero_mult_R3: assert (p_o == '0 && row_active_o == '0)
        else $error("zero multiplier gave nonzero result");
    end
    if (a_i == '0) begin
      assert_zero_mcand_R4: assert (p_o == '0)
        else $error("zero multiplicand gave nonzero product");
    end
    if (b_i == N'(1)) begin
      assert_unit_R5: assert (p_o == a_ext && row_active_o == '0)
        else $error("unit multiplier wrong");
    end
    if ($onehot(b_i)) begin
      assert_single_row_R6: assert ($countones(row_active_o) <= 1)
        else $error("more than one row active for single-bit multiplier");
    end
  end
endmodule

// File: tb/rbm_mult_test.sv
`timescale 1ns/1ps
module rbm_mult_test;
  localparam int N = 4;
  localparam int W = 2 * N;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic [N-1:0] a, b;
  logic [W-1:0] p;
  logic [N-2:0] act;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rbm_mult #(.N(N)) uut (
    .a_i(a), .b_i(b), .p_o(p), .row_active_o(act)
  );

  task automatic chk(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s a=%0d b=%0d actual=%0d expected=%0d", req, a, b, got, exp);
    end
  endtask

  task automatic apply(input int av, input int bv);
    @(negedge clk);
    a = N'(av);
    b = N'(bv);
    #1;
  endtask

  initial begin
    a = '0;
    b = '0;
    #1;
    chk("R3 initial", p, '0);
    chk("R3 initial flags", W'(act), '0);

    // R1 R2: exhaustive sweep
    for (int i = 0; i < (1 << N); i++) begin
      for (int k = 0; k < (1 << N); k++) begin
        apply(i, k);
        chk("R1", p, W'(i * k));
        chk("R2", W'(act), W'(k >> 1));
      end
    end

    // R1 documented case: 1011 x 1010, row for bit 2 bypassed
    apply(11, 10);
    chk("R1 11x10", p, W'(110));
    chk("R2 11x10 flags", W'(act), W'(3'b101));

    // R3
    apply(9, 0);
    chk("R3 b=0", p, '0);
    chk("R3 b=0 flags", W'(act), '0);

    // R4
    apply(0, 15);
    chk("R4 a=0", p, '0);
    chk("R4 a=0 flags", W'(act), W'(3'b111));

    // R5
    for (int i = 0; i < (1 << N); i += 5) begin
      apply(i, 1);
      chk("R5", p, W'(i));
      chk("R5 flags", W'(act), '0);
    end

    // R6
    for (int s = 0; s < N; s++) begin
      apply(13, 1 << s);
      chk("R6", p, W'(13 << s));
      chk("R6 flags", W'(act), W'((1 << s) >> 1));
    end

    // R7
    apply(15, 15);
    chk("R7 max", p, W'(225));

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule